// File: doc/BRIEF.md
# Scan Test Access Port with Identification and Pin Boundary Chain

This block is a four-wire scan test port controller (clock `tck`, mode select `tms`, serial in `tdi`, serial out `tdo`, plus an asynchronous active-low port reset `trst_n`). A sixteen-state controller steps on the rising edge of `tck` under `tms`. It steers serial data through one of three data paths: a one-bit bypass stage, a fixed 32-bit identification word, or a boundary chain of three cells for each bidirectional pin. A 3-bit instruction register selects the path.

A tester uses the port in three ways. It reads the identification word straight after reset, because reset leaves the identification instruction selected. It snapshots and preloads the pin states while the core keeps running. It takes over the pin drivers to test board wiring. While the port is in reset, or holds any instruction other than the external-test instruction, the pads follow the core (`core_out`, `core_oe`). Under the external-test instruction they follow the update stage of the boundary chain.

The controller states and their transitions on `tms` = 0 / 1 are:
- Reset: to Idle / Reset.
- Idle: to Idle / DR-Select.
- DR-Select: to DR-Capture / IR-Select.
- DR-Capture: to DR-Shift / DR-Exit1.
- DR-Shift: to DR-Shift / DR-Exit1.
- DR-Exit1: to DR-Pause / DR-Update.
- DR-Pause: to DR-Pause / DR-Exit2.
- DR-Exit2: to DR-Shift / DR-Update.
- DR-Update: to Idle / DR-Select.
- IR-Select: to IR-Capture / Reset.
- IR-Capture, IR-Shift, IR-Exit1, IR-Pause, IR-Exit2 and IR-Update: the same as their DR counterparts.

Top module: `scan_port_top`

## Requirements
- R1: The controller follows the transitions listed above on each rising `tck` edge. `trst_n` low forces the Reset state and the identification instruction at once, without a clock, and hands the pads back to the core.
- R2: Five consecutive rising `tck` edges with `tms` = 1 bring the controller to Reset from any state.
- R3: The instruction changes only on the falling `tck` edge. It takes the value 3'b011 (identification) in the Reset state, and takes the shifted value in IR-Update.
- R4: IR-Capture loads 3'b001 into the instruction shift stage. The stage shifts from `tdi` towards `tdo`, least significant bit first, so the first bit seen on `tdo` in IR-Shift is 1.
- R5: Under instruction 3'b011, DR-Capture loads 32'h3003C083 and the word leaves on `tdo` least significant bit first. The word's fields are version 4'h3 in bits 31:28, device code 16'h003C in bits 27:12, maker code 11'h041 in bits 11:1, and bit 0 = 1. From Reset, `tms` = 0,1,0,0 reaches DR-Shift with bit 0 on `tdo`.
- R6: Instruction 3'b111, and the unassigned codes 3'b001, 3'b100, 3'b101 and 3'b110, select a one-bit bypass stage. It captures 0, and each `tdi` bit reappears on `tdo` one shift later.
- R7: The boundary chain is 3*NPINS cells long. From `tdi` it runs pin NPINS-1 first, down to pin 0. Within each pin the order is input, output, enable, so chain bit 3p+2 is the input cell of pin p, 3p+1 is its output cell, 3p is its enable cell, and bit 0 feeds `tdo`.
- R8: Under 3'b010 or 3'b000, DR-Capture loads `pin_in[p]`, `core_out[p]` and `core_oe[p]` into the input, output and enable cells of pin p.
- R9: Instruction 3'b010 (sample/preload) loads the update stage in DR-Update and leaves `pin_out`/`pin_oe` equal to `core_out`/`core_oe`.
- R10: Under instruction 3'b000 (external test), `pin_out[p]` and `pin_oe[p]` come from the update stage of the output and enable cells of pin p. Under every other instruction they equal `core_out` and `core_oe`.
- R11: `tdo` changes only on the falling `tck` edge. It is 0 whenever the controller is in neither shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| pin_in | input | NPINS | Values seen at the bidirectional pads |
| core_out | input | NPINS | Functional output data from the core |
| core_oe | input | NPINS | Functional output enables from the core |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enables to the pads |

## Verification
A wrong controller state shows at the ports within half a `tck` period. Leaving or missing a shift state changes `tdo` at the next falling edge, so a misrouted transition through the pause states drops or repeats identification bits at a known place in the stream. A wrong instruction shows as the wrong serial length or content: a bypass read where the identification word was expected, a capture pattern other than 001, or pads that leave core control one falling edge after IR-Update when they should not. A chain cell that is misplaced or missing shifts every later boundary bit by one position. That error shows in the captured pattern, and in the pad values after the next DR-Update under external test.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHF,
        ST_DR_EX1,
        ST_DR_PAU,
        ST_DR_EX2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHF,
        ST_IR_EX1,
        ST_IR_PAU,
        ST_IR_EX2,
        ST_IR_UPD
    } tap_state_e;

    // Action strobes decoded from the controller state.
    typedef struct packed {
        logic in_reset;
        logic capture_dr;
        logic shift_dr;
        logic update_dr;
        logic capture_ir;
        logic shift_ir;
        logic update_ir;
    } tap_ctl_t;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUNDARY
    } dr_path_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
    localparam logic [IR_W-1:0] OP_IDENT   = 3'b011;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    tap_state_e state_q;
    tap_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_DR_SEL : ST_IDLE;
            ST_DR_SEL: state_d = tms ? ST_IR_SEL : ST_DR_CAP;
            ST_DR_CAP: state_d = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_SHF: state_d = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_EX1: state_d = tms ? ST_DR_UPD : ST_DR_PAU;
            ST_DR_PAU: state_d = tms ? ST_DR_EX2 : ST_DR_PAU;
            ST_DR_EX2: state_d = tms ? ST_DR_UPD : ST_DR_SHF;
            ST_DR_UPD: state_d = tms ? ST_DR_SEL : ST_IDLE;
            ST_IR_SEL: state_d = tms ? ST_RESET  : ST_IR_CAP;
            ST_IR_CAP: state_d = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_SHF: state_d = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_EX1: state_d = tms ? ST_IR_UPD : ST_IR_PAU;
            ST_IR_PAU: state_d = tms ? ST_IR_EX2 : ST_IR_PAU;
            ST_IR_EX2: state_d = tms ? ST_IR_UPD : ST_IR_SHF;
            ST_IR_UPD: state_d = tms ? ST_DR_SEL : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_RESET:  ctl.in_reset   = 1'b1;
            ST_DR_CAP: ctl.capture_dr = 1'b1;
            ST_DR_SHF: ctl.shift_dr   = 1'b1;
            ST_DR_UPD: ctl.update_dr  = 1'b1;
            ST_IR_CAP: ctl.capture_ir = 1'b1;
            ST_IR_SHF: ctl.shift_ir   = 1'b1;
            ST_IR_UPD: ctl.update_ir  = 1'b1;
            default:   ctl            = '0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic            sr_lsb,
    output logic [IR_W-1:0] instr
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] hold_q;

    // Shift stage: rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= IR_CAPTURE;
        end else if (ctl.capture_ir) begin
            sr_q <= IR_CAPTURE;
        end else if (ctl.shift_ir) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Hold stage: falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            hold_q <= OP_IDENT;
        end else if (ctl.in_reset) begin
            hold_q <= OP_IDENT;
        end else if (ctl.update_ir) begin
            hold_q <= sr_q;
        end
    end

    assign sr_lsb = sr_q[0];
    assign instr  = hold_q;

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
    parameter int NPINS = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    output logic             so,
    output logic [NPINS-1:0] upd_out,
    output logic [NPINS-1:0] upd_oe
);

    localparam int CELLS = 3 * NPINS;

    logic [CELLS-1:0] chain_q;
    logic [CELLS-1:0] cap_vec;

    // Three cells per pin; the highest pin sits next to tdi
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign cap_vec[3*p+2] = pin_in[p];
        assign cap_vec[3*p+1] = core_out[p];
        assign cap_vec[3*p]   = core_oe[p];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            chain_q <= '0;
        end else if (capture) begin
            chain_q <= cap_vec;
        end else if (shift) begin
            chain_q <= {tdi, chain_q[CELLS-1:1]};
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_out <= '0;
            upd_oe  <= '0;
        end else if (update) begin
            for (int p = 0; p < NPINS; p++) begin
                upd_out[p] <= chain_q[3*p+1];
                upd_oe[p]  <= chain_q[3*p];
            end
        end
    end

    assign so = chain_q[0];

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
    import scan_pkg::*;
#(
    parameter int          NPINS      = 4,
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'h003C,
    parameter logic [10:0] ID_MAKER   = 11'h041
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);

    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_e      state_q;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] instr_q;
    logic            ir_lsb;
    dr_path_e        path;
    logic            bsr_so;
    logic [NPINS-1:0] upd_out;
    logic [NPINS-1:0] upd_oe;
    logic [ID_W-1:0] id_sr;
    logic            byp_q;
    logic            dr_lsb;
    logic            tdo_q;
    logic            extest;

    scan_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state_q),
        .ctl    (ctl)
    );

    scan_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .ctl    (ctl),
        .sr_lsb (ir_lsb),
        .instr  (instr_q)
    );

    // Instruction decode: any code not assigned falls to bypass
    always_comb begin
        unique case (instr_q)
            OP_IDENT:              path = PATH_IDENT;
            OP_SAMPLE, OP_EXTEST:  path = PATH_BOUNDARY;
            default:               path = PATH_BYPASS;
        endcase
    end

    scan_bsr #(.NPINS(NPINS)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .capture  (ctl.capture_dr && (path == PATH_BOUNDARY)),
        .shift    (ctl.shift_dr   && (path == PATH_BOUNDARY)),
        .update   (ctl.update_dr  && (path == PATH_BOUNDARY)),
        .pin_in   (pin_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .so       (bsr_so),
        .upd_out  (upd_out),
        .upd_oe   (upd_oe)
    );

    // Identification and bypass stages
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sr <= '0;
            byp_q <= 1'b0;
        end else begin
            if (path == PATH_IDENT) begin
                if (ctl.capture_dr) begin
                    id_sr <= ID_WORD;
                end else if (ctl.shift_dr) begin
                    id_sr <= {tdi, id_sr[ID_W-1:1]};
                end
            end
            if (path == PATH_BYPASS) begin
                if (ctl.capture_dr) begin
                    byp_q <= 1'b0;
                end else if (ctl.shift_dr) begin
                    byp_q <= tdi;
                end
            end
        end
    end

    always_comb begin
        unique case (path)
            PATH_IDENT:    dr_lsb = id_sr[0];
            PATH_BOUNDARY: dr_lsb = bsr_so;
            default:       dr_lsb = byp_q;
        endcase
    end

    // Serial output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
        end else if (ctl.shift_ir) begin
            tdo_q <= ir_lsb;
        end else if (ctl.shift_dr) begin
            tdo_q <= dr_lsb;
        end else begin
            tdo_q <= 1'b0;
        end
    end

    assign tdo     = tdo_q;
    assign extest  = (instr_q == OP_EXTEST);
    assign pin_out = extest ? upd_out : core_out;
    assign pin_oe  = extest ? upd_oe  : core_oe;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic             tdo,
    input tap_state_e       state,
    input logic [IR_W-1:0]  instr,
    input logic [NPINS-1:0] core_out,
    input logic [NPINS-1:0] core_oe,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_cnt <= '0;
        end else if (!tms) begin
            ones_cnt <= '0;
        end else if (ones_cnt != 3'd7) begin
            ones_cnt <= ones_cnt + 3'd1;
        end
    end

    assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt >= 3'd5) |-> (state == ST_RESET));

    assert_reset_ident_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && $past(state) == ST_RESET) |-> (instr == OP_IDENT));

    assert_instr_change_R3: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(instr) |-> (state == ST_IR_UPD || state == ST_RESET));

    assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_SHF && $past(state) == ST_IR_CAP) |-> (tdo == 1'b1));

    assert_ident_lsb_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_DR_SHF && $past(state) == ST_DR_CAP && instr == OP_IDENT)
        |-> (tdo == 1'b1));

    assert_core_pins_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (instr != OP_EXTEST) |-> (pin_out == core_out && pin_oe == core_oe));

    assert_tdo_idle_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_DR_SHF && state != ST_IR_SHF) |-> (tdo == 1'b0));

endmodule

bind scan_port_top scan_port_chk #(.NPINS(NPINS)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tdo      (tdo),
    .state    (state_q),
    .instr    (instr_q),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/scan_port_top_test.sv
module scan_port_top_test;

    localparam int NPINS = 4;
    localparam int CELLS = 3 * NPINS;
    localparam logic [31:0] ID_EXP = 32'h3003C083;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic             tdo;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] core_out = '0;
    logic [NPINS-1:0] core_oe = '0;
    logic [NPINS-1:0] pin_out;
    logic [NPINS-1:0] pin_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    scan_port_top #(.NPINS(NPINS)) uut (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .tdi      (tdi),
        .tdo      (tdo),
        .pin_in   (pin_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always #5 tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive tms/tdi in the low phase, take the rising edge, read tdo after the falling edge
    task automatic tick(input logic t, input logic d, output logic o);
        tms = t;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        o = tdo;
    endtask

    // From Idle: full scan of n bits through DR (ir=0) or IR (ir=1), back to Idle
    task automatic scan(input logic ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout);
        logic o;
        dout = '0;
        tick(1'b1, 1'b0, o);
        if (ir) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        dout[0] = o;
        for (int i = 0; i < n - 1; i++) begin
            tick(1'b0, din[i], o);
            dout[i+1] = o;
        end
        tick(1'b1, din[n-1], o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    function automatic logic [63:0] cap_pattern(input logic [NPINS-1:0] pi,
                                                input logic [NPINS-1:0] co,
                                                input logic [NPINS-1:0] ce);
        logic [63:0] v = '0;
        for (int p = 0; p < NPINS; p++) begin
            v[3*p+2] = pi[p];
            v[3*p+1] = co[p];
            v[3*p]   = ce[p];
        end
        return v;
    endfunction

    task automatic test_reset;
        check("R1 tdo after reset", {63'b0, tdo}, 64'd0);
        check("R10 pin_out follows core in reset", {60'b0, pin_out}, {60'b0, core_out});
        check("R10 pin_oe follows core in reset", {60'b0, pin_oe}, {60'b0, core_oe});
    endtask

    task automatic test_ident_from_reset;
        logic o;
        logic [63:0] dout;
        // Reset -> Idle, then scan uses 1,0,0: overall 0,1,0,0 to DR-Shift
        tick(1'b0, 1'b0, o);
        scan(1'b0, 32, 64'd0, dout);
        check("R5 identification word", {32'b0, dout[31:0]}, {32'b0, ID_EXP});
    endtask

    task automatic test_pause_path;
        logic o;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R5 bit0 on entering DR-Shift", {63'b0, o}, {63'b0, ID_EXP[0]});
        tick(1'b0, 1'b0, o);
        check("R5 bit1", {63'b0, o}, {63'b0, ID_EXP[1]});
        // tdo must not move on the rising edge
        tms = 1'b0;
        @(posedge tck);
        #1;
        check("R11 tdo stable across rising edge", {63'b0, tdo}, {63'b0, ID_EXP[1]});
        @(negedge tck);
        #1;
        check("R11 tdo moves at falling edge", {63'b0, tdo}, {63'b0, ID_EXP[2]});
        tick(1'b1, 1'b0, o);
        check("R11 tdo zero in DR-Exit1", {63'b0, o}, 64'd0);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R1 pause/exit2 resumes shift", {63'b0, o}, {63'b0, ID_EXP[3]});
        tick(1'b0, 1'b0, o);
        check("R1 next bit after resume", {63'b0, o}, {63'b0, ID_EXP[4]});
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic load_ir(input logic [2:0] code, input string req);
        logic [63:0] dout;
        scan(1'b1, 3, {61'b0, code}, dout);
        check(req, {61'b0, dout[2:0]}, 64'd1);
    endtask

    task automatic test_bypass(input logic [2:0] code);
        logic [63:0] dout;
        logic [63:0] din = 64'hB4;
        load_ir(code, "R4 IR capture pattern");
        scan(1'b0, 8, din, dout);
        check($sformatf("R6 bypass for code %b", code), {56'b0, dout[7:0]},
              {56'b0, din[6:0], 1'b0});
    endtask

    task automatic test_sample;
        logic [63:0] dout;
        logic [63:0] din = 64'hA5C;
        core_out = 4'b1010;
        core_oe  = 4'b0110;
        pin_in   = 4'b0011;
        load_ir(3'b010, "R4 IR capture before sample");
        scan(1'b0, CELLS, din, dout);
        check("R8 R7 sample capture order", {52'b0, dout[11:0]},
              cap_pattern(pin_in, core_out, core_oe));
        check("R9 pins stay functional out", {60'b0, pin_out}, {60'b0, core_out});
        check("R9 pins stay functional oe", {60'b0, pin_oe}, {60'b0, core_oe});
    endtask

    task automatic test_extest;
        logic [63:0] dout;
        logic [63:0] pre = 64'hA5C;
        logic [63:0] din2 = 64'h3C9;
        logic [NPINS-1:0] eo;
        logic [NPINS-1:0] ee;
        load_ir(3'b000, "R4 IR capture before extest");
        for (int p = 0; p < NPINS; p++) begin
            eo[p] = pre[3*p+1];
            ee[p] = pre[3*p];
        end
        check("R10 preloaded out drives pins", {60'b0, pin_out}, {60'b0, eo});
        check("R10 preloaded oe drives pins", {60'b0, pin_oe}, {60'b0, ee});
        pin_in = 4'b1100;
        scan(1'b0, CELLS, din2, dout);
        check("R8 extest capture", {52'b0, dout[11:0]},
              cap_pattern(pin_in, core_out, core_oe));
        for (int p = 0; p < NPINS; p++) begin
            eo[p] = din2[3*p+1];
            ee[p] = din2[3*p];
        end
        check("R10 R7 new out after update", {60'b0, pin_out}, {60'b0, eo});
        check("R10 R7 new oe after update", {60'b0, pin_oe}, {60'b0, ee});
    endtask

    task automatic test_five_ones;
        logic o;
        logic [63:0] dout;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        check("R2 R3 pins back to core", {60'b0, pin_out}, {60'b0, core_out});
        tick(1'b0, 1'b0, o);
        scan(1'b0, 32, 64'd0, dout);
        check("R2 R3 identification after five ones", {32'b0, dout[31:0]}, {32'b0, ID_EXP});
    endtask

    task automatic test_async_reset;
        logic o;
        logic [63:0] dout;
        load_ir(3'b000, "R4 IR capture before async reset");
        core_out = 4'b0101;
        #2;
        trst_n = 1'b0;
        #1;
        check("R1 async reset returns pins", {60'b0, pin_out}, {60'b0, core_out});
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o);
        scan(1'b0, 32, 64'd0, dout);
        check("R1 R3 identification after async reset", {32'b0, dout[31:0]}, {32'b0, ID_EXP});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        core_out = 4'b0110;
        core_oe  = 4'b1001;
        repeat (3) @(negedge tck);
        #1;
        trst_n = 1'b1;
        test_reset();
        test_ident_from_reset();
        test_pause_path();
        test_bypass(3'b111);
        test_bypass(3'b001);
        test_bypass(3'b100);
        test_bypass(3'b101);
        test_bypass(3'b110);
        test_sample();
        test_extest();
        test_five_ones();
        test_async_reset();
        finish_run();
    end

endmodule